// File: doc/BRIEF.md
# Three-Channel Debug Trigger Sequencer

This block sits behind three comparator channels of an on-chip debug unit. Each comparator reports a hit as a one-cycle pulse on its own match line. Once software arms the block, it walks a small state machine of three working states and one terminal state. Each working state has a 4-bit routing code. The code says which channel hits move the machine, and where they move it. When the machine reaches the terminal state, the block emits a one-cycle trigger pulse and disarms itself.

While armed, every channel hit sets that channel's sticky flag. The flags stay set after the session ends, so a debugger can later find out which comparators fired. Only the next arm clears them. A read port returns the flag vector, but only at one fixed register offset and only when the register-window select holds its unlocking value. Everywhere else the port reads zero.

Top module: `dbgseq_top`

## Requirements
- R1: Reset (synchronous, active high) puts the state at State1 (code 0), clears all flags and the trigger, and leaves the block disarmed, so match pulses after reset change neither state nor flags until the first arm.
- R2: A cycle with `arm_stb` high clears all flags, moves the state to State1 and arms the block, and any match pulse in that same cycle is ignored.
- R3: State codes are State1=0, State2=1, State3=2, Final=3. The routing code of the current working state (`cfg_s1`, `cfg_s2`, `cfg_s3`) sets the destination of each channel's hit as follows. 1: ch0→Final. 2: ch1→Final. 3: ch2→Final. 4: ch0→State2, ch1→Final. 5: ch0→State3, ch2→Final. 6: ch0→Final, ch1→State1. 7: ch1→State2, ch2→Final. 8: ch0→Final, ch2→State3. 9: ch0→State1, ch1→State2. 10: ch1→State3, ch2→State2. 11: ch0→State3, ch1→Final, ch2→State2. The new state is visible one clock after the hit.
- R4: Codes 0, 12, 13, 14 and 15 are reserved and cause no transition. A hit on a channel that the current code does not name also causes no transition. In both cases the state holds.
- R5: When several channels hit in one cycle and at least one of them is routed to Final, the machine goes to Final.
- R6: When several routed channels hit in one cycle and none of them leads to Final, the lowest-numbered channel among them decides the next state.
- R7: Entering Final raises `trig_o` for exactly one cycle, the same cycle the state shows Final, and disarms the block. After that the state stays Final and the flags do not change until the next arm.
- R8: While armed, and outside the arm cycle, a hit on channel i sets flag bit i whether or not the channel is routed. Flags never clear except by arm or reset, a set flag does not block other flags, and repeated hits leave a set flag unchanged.
- R9: `rd_data` shows the flags in bits 2:0 and zeros in bits 7:3 when `rd_addr` is 0x27 and `rd_win` is 2'b11. For any other address or window value it reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_stb | input | 1 | Arm strobe: clears flags, restarts at State1 |
| match_i | input | 3 | One-cycle hit pulse per comparator channel |
| cfg_s1 | input | 4 | Routing code used in State1 |
| cfg_s2 | input | 4 | Routing code used in State2 |
| cfg_s3 | input | 4 | Routing code used in State3 |
| rd_addr | input | 8 | Register read offset |
| rd_win | input | 2 | Register-window select |
| state_o | output | 2 | Current sequencer state |
| trig_o | output | 1 | One-cycle pulse on entering Final |
| flags_o | output | 3 | Sticky per-channel hit flags |
| rd_data | output | 8 | Register read data |

## Verification
The bench drives the machine into each working state and applies every routing code, 0 through 15, with every non-empty combination of the three hit lines. Single-channel patterns show whether each table entry is right. Multi-channel patterns with mixed destinations show whether Final beats a lower channel and whether, when Final is not involved, the lowest channel wins. Patterns that only hit unnamed channels or use reserved codes show whether an ignored hit still sets its flag without moving the state. Separate runs fire hits after reset, in the arm cycle and after Final to show disarmed behaviour, and a sweep over every address and window value checks the read gating.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int CH_COUNT = 3;
    localparam int ST_COUNT = 3;
    localparam int CODE_W   = 4;

    typedef enum logic [1:0] {
        ST_ONE   = 2'd0,
        ST_TWO   = 2'd1,
        ST_THREE = 2'd2,
        ST_FINAL = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        TG_NONE  = 3'd0,
        TG_ONE   = 3'd1,
        TG_TWO   = 3'd2,
        TG_THREE = 3'd3,
        TG_FINAL = 3'd4
    } tgt_e;

    typedef tgt_e [CH_COUNT-1:0] route_t;

    // Destination of each channel's hit for a given routing code
    function automatic route_t route_of(input logic [CODE_W-1:0] code);
        route_t r;
        for (int i = 0; i < CH_COUNT; i++) r[i] = TG_NONE;
        case (code)
            4'd1:  r[0] = TG_FINAL;
            4'd2:  r[1] = TG_FINAL;
            4'd3:  r[2] = TG_FINAL;
            4'd4:  begin r[0] = TG_TWO;   r[1] = TG_FINAL; end
            4'd5:  begin r[0] = TG_THREE; r[2] = TG_FINAL; end
            4'd6:  begin r[0] = TG_FINAL; r[1] = TG_ONE;   end
            4'd7:  begin r[1] = TG_TWO;   r[2] = TG_FINAL; end
            4'd8:  begin r[0] = TG_FINAL; r[2] = TG_THREE; end
            4'd9:  begin r[0] = TG_ONE;   r[1] = TG_TWO;   end
            4'd10: begin r[1] = TG_THREE; r[2] = TG_TWO;   end
            4'd11: begin r[0] = TG_THREE; r[1] = TG_FINAL; r[2] = TG_TWO; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic seq_state_e state_of(input tgt_e t);
        case (t)
            TG_TWO:   return ST_TWO;
            TG_THREE: return ST_THREE;
            TG_FINAL: return ST_FINAL;
            default:  return ST_ONE;
        endcase
    endfunction

endpackage

// File: rtl/dbgseq_route.sv
module dbgseq_route
    import dbgseq_pkg::*;
(
    input  seq_state_e                       cur_state,
    input  logic [ST_COUNT-1:0][CODE_W-1:0]  cfg,
    output route_t                           route
);
    route_t per_state [ST_COUNT];

    // One decoder per working state; the current state picks among them
    for (genvar g = 0; g < ST_COUNT; g++) begin : g_dec
        assign per_state[g] = route_of(cfg[g]);
    end

    always_comb begin
        for (int i = 0; i < CH_COUNT; i++) route[i] = TG_NONE;
        case (cur_state)
            ST_ONE:   route = per_state[0];
            ST_TWO:   route = per_state[1];
            ST_THREE: route = per_state[2];
            default:  ;
        endcase
    end
endmodule

// File: rtl/dbgseq_arbiter.sv
module dbgseq_arbiter
    import dbgseq_pkg::*;
(
    input  logic [CH_COUNT-1:0] match,
    input  route_t              route,
    output logic                fire,
    output logic                to_final,
    output seq_state_e          nxt
);
    logic [CH_COUNT-1:0] fin_hit;
    logic [CH_COUNT-1:0] step_hit;
    tgt_e                pick;

    for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
        assign fin_hit[c]  = match[c] && (route[c] == TG_FINAL);
        assign step_hit[c] = match[c] && (route[c] != TG_NONE) && (route[c] != TG_FINAL);
    end

    // Final beats everything; otherwise the lowest channel wins
    always_comb begin
        pick = TG_NONE;
        for (int i = CH_COUNT-1; i >= 0; i--) begin
            if (step_hit[i]) pick = route[i];
        end
        to_final = |fin_hit;
        fire     = to_final || (|step_hit);
        nxt      = to_final ? ST_FINAL : state_of(pick);
    end
endmodule

// File: rtl/dbgseq_flags.sv
module dbgseq_flags
    import dbgseq_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h27,
    parameter logic [1:0]       WIN_KEY  = 2'b11
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                upd,
    input  logic [CH_COUNT-1:0] match,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [1:0]          rd_win,
    output logic [CH_COUNT-1:0] flags,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int PAD_W = DATA_W - CH_COUNT;

    logic rd_hit;

    always_ff @(posedge clk) begin
        if (rst || clr)  flags <= '0;
        else if (upd)    flags <= flags | match;
    end

    assign rd_hit  = (rd_addr == FLAG_OFS) && (rd_win == WIN_KEY);
    assign rd_data = rd_hit ? {{PAD_W{1'b0}}, flags} : '0;

    AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((flags & $past(flags)) == $past(flags)));                // R8
    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!clr && !upd) |=> $stable(flags));                                // R8
    AST_RD_GATED: assert property (@(posedge clk) disable iff (rst)
        (rd_win != WIN_KEY) |-> (rd_data == '0));                          // R9
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
    import dbgseq_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 8,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 8'h27,
    parameter logic [1:0]       WIN_KEY  = 2'b11
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_stb,
    input  logic [2:0]          match_i,
    input  logic [3:0]          cfg_s1,
    input  logic [3:0]          cfg_s2,
    input  logic [3:0]          cfg_s3,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [1:0]          rd_win,
    output logic [1:0]          state_o,
    output logic                trig_o,
    output logic [2:0]          flags_o,
    output logic [DATA_W-1:0]   rd_data
);
    seq_state_e state_q;
    seq_state_e nxt;
    logic       armed_q;
    logic       fire;
    logic       to_final;
    logic       live;
    route_t     route;

    assign live = armed_q && !arm_stb;

    dbgseq_route u_route (
        .cur_state (state_q),
        .cfg       ({cfg_s3, cfg_s2, cfg_s1}),
        .route     (route)
    );

    dbgseq_arbiter u_arb (
        .match    (match_i),
        .route    (route),
        .fire     (fire),
        .to_final (to_final),
        .nxt      (nxt)
    );

    dbgseq_flags #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FLAG_OFS (FLAG_OFS),
        .WIN_KEY  (WIN_KEY)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (arm_stb),
        .upd     (live),
        .match   (match_i),
        .rd_addr (rd_addr),
        .rd_win  (rd_win),
        .flags   (flags_o),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ONE;
            armed_q <= 1'b0;
            trig_o  <= 1'b0;
        end else begin
            trig_o <= 1'b0;
            if (arm_stb) begin
                state_q <= ST_ONE;
                armed_q <= 1'b1;
            end else if (live && fire) begin
                state_q <= nxt;
                if (to_final) begin
                    armed_q <= 1'b0;
                    trig_o  <= 1'b1;
                end
            end
        end
    end

    assign state_o = state_q;

    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> !trig_o);                                               // R7
    AST_TRIG_AT_FINAL: assert property (@(posedge clk) disable iff (rst)
        trig_o |-> (state_o == ST_FINAL));                                 // R7
    AST_FINAL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_FINAL && !arm_stb) |=> (state_o == ST_FINAL && !trig_o)); // R7
    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (rst)
        arm_stb |=> (state_o == ST_ONE && flags_o == '0 && !trig_o));      // R2
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!arm_stb && match_i == '0) |=> $stable(state_o));                 // R4
endmodule

// File: tb/sim_dbgseq_top.sv
`timescale 1ns/1ps
module sim_dbgseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm_stb = 1'b0;
    logic [2:0] match_i = '0;
    logic [3:0] cfg_s1 = '0, cfg_s2 = '0, cfg_s3 = '0;
    logic [7:0] rd_addr = 8'h27;
    logic [1:0] rd_win = 2'b11;
    logic [1:0] state_o;
    logic       trig_o;
    logic [2:0] flags_o;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dbgseq_top u0 (
        .clk(clk), .rst(rst), .arm_stb(arm_stb), .match_i(match_i),
        .cfg_s1(cfg_s1), .cfg_s2(cfg_s2), .cfg_s3(cfg_s3),
        .rd_addr(rd_addr), .rd_win(rd_win),
        .state_o(state_o), .trig_o(trig_o), .flags_o(flags_o), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Destination per requirement R3: 0 none, 1..3 working state, 4 Final
    function automatic int dest(input int code, input int ch);
        case (code)
            1:  return (ch == 0) ? 4 : 0;
            2:  return (ch == 1) ? 4 : 0;
            3:  return (ch == 2) ? 4 : 0;
            4:  return (ch == 0) ? 2 : (ch == 1) ? 4 : 0;
            5:  return (ch == 0) ? 3 : (ch == 2) ? 4 : 0;
            6:  return (ch == 0) ? 4 : (ch == 1) ? 1 : 0;
            7:  return (ch == 1) ? 2 : (ch == 2) ? 4 : 0;
            8:  return (ch == 0) ? 4 : (ch == 2) ? 3 : 0;
            9:  return (ch == 0) ? 1 : (ch == 1) ? 2 : 0;
            10: return (ch == 1) ? 3 : (ch == 2) ? 2 : 0;
            11: return (ch == 0) ? 3 : (ch == 1) ? 4 : 2;
            default: return 0;
        endcase
    endfunction

    task automatic step(input logic a, input logic [2:0] m);
        @(negedge clk);
        arm_stb = a;
        match_i = m;
        @(posedge clk);
        #1;
        @(negedge clk);
        arm_stb = 1'b0;
        match_i = '0;
    endtask

    task automatic set_cfg(input int st, input int code);
        case (st)
            0: cfg_s1 = code[3:0];
            1: cfg_s2 = code[3:0];
            default: cfg_s3 = code[3:0];
        endcase
    endtask

    task automatic trial(input int st, input int code, input int pat);
        int path_flags;
        int exp_st;
        int n_eff;
        bit fin;
        string tag;
        @(negedge clk);
        cfg_s1 = 4'd4; cfg_s2 = 4'd10; cfg_s3 = 4'd0;
        step(1'b1, 3'b000);
        path_flags = 0;
        if (st >= 1) begin step(1'b0, 3'b001); path_flags = 1; end
        if (st >= 2) begin step(1'b0, 3'b010); path_flags = 3; end
        chk("R3 path", int'(state_o), st);
        set_cfg(st, code);
        fin = 0; exp_st = st; n_eff = 0;
        for (int c = 0; c < 3; c++)
            if (pat[c] && dest(code, c) != 0) n_eff++;
        for (int c = 0; c < 3; c++)
            if (pat[c] && dest(code, c) == 4) fin = 1;
        if (fin) exp_st = 3;
        else begin
            for (int c = 2; c >= 0; c--)
                if (pat[c] && dest(code, c) != 0) exp_st = dest(code, c) - 1;
        end
        if (n_eff == 0)          tag = "R4";
        else if (fin && n_eff > 1) tag = "R5";
        else if (n_eff > 1)      tag = "R6";
        else                     tag = "R3";
        @(negedge clk);
        match_i = pat[2:0];
        @(posedge clk);
        #1;
        chk($sformatf("%s state st=%0d code=%0d pat=%0d", tag, st, code, pat), int'(state_o), exp_st);
        chk($sformatf("R7 trig st=%0d code=%0d pat=%0d", st, code, pat), int'(trig_o), int'(fin));
        chk($sformatf("R8 flags st=%0d code=%0d pat=%0d", st, code, pat), int'(flags_o), path_flags | pat);
        @(negedge clk);
        match_i = '0;
        @(posedge clk);
        #1;
        chk("R7 trig drops", int'(trig_o), 0);
        if (fin) begin
            step(1'b0, 3'b111);
            chk("R7 final holds", int'(state_o), 3);
            chk("R7 flags frozen", int'(rd_data), path_flags | pat);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", int'(state_o), 0);
        chk("R1 reset flags", int'(flags_o), 0);
        chk("R1 reset trig", int'(trig_o), 0);
        @(negedge clk);
        rst = 1'b0;
        cfg_s1 = 4'd1;
        step(1'b0, 3'b111);
        chk("R1 disarmed state", int'(state_o), 0);
        chk("R1 disarmed flags", int'(flags_o), 0);
        chk("R1 disarmed trig", int'(trig_o), 0);

        // Arm cycle ignores simultaneous hits and clears earlier flags
        cfg_s1 = 4'd9;
        step(1'b1, 3'b000);
        step(1'b0, 3'b110);
        chk("R8 flags set", int'(flags_o), 6);
        chk("R6 ch1 wins", int'(state_o), 1);
        step(1'b1, 3'b111);
        chk("R2 arm state", int'(state_o), 0);
        chk("R2 arm flags", int'(flags_o), 0);
        step(1'b0, 3'b000);
        chk("R2 arm-cycle hits ignored", int'(flags_o), 0);

        for (int st = 0; st < 3; st++)
            for (int code = 0; code < 16; code++)
                for (int pat = 1; pat < 8; pat++)
                    trial(st, code, pat);

        // Read-window gating with flags 101
        cfg_s1 = 4'd0;
        step(1'b1, 3'b000);
        step(1'b0, 3'b101);
        for (int a = 0; a < 256; a++)
            for (int w = 0; w < 4; w++) begin
                rd_addr = a[7:0];
                rd_win  = w[1:0];
                #1;
                chk($sformatf("R9 read a=%0d w=%0d", a, w), int'(rd_data),
                    (a == 8'h27 && w == 3) ? 5 : 0);
            end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule